// File: doc/BRIEF.md
# Bidirectional GPIO port register set

This block is one memory-mapped general-purpose I/O port with a width set by a parameter. Each pin has a tri-state pad: the block drives an output enable, an output value and a weak pull-up enable, and it receives the pad level. Software sets each pin's direction in a direction register. It writes output values into an output latch. It reads the live pin levels back through a separate pin register. Reads of the pin register return what is on the pads after a two-flop synchroniser. Writes to that same address go to the latch. The latch can also be read back at its own address, so read-modify-write on the latch is not disturbed by pins that are held low by outside circuitry.

Weak pull-ups are turned on for the whole port by clearing one active-low control bit, and a per-pin mask selects which pins may use them. A pull-up is removed automatically from any pin that is currently driving. A peripheral can take over any pin's direction through a per-pin override input, and the direction register is then ignored for that pin. The reset direction is a per-pin parameter.

Top module: `gpio_port`

## Requirements
- R1: The direction register (address 0) holds one bit per pin. A bit of 1 makes the pin an input with `pad_oe` low. A bit of 0 makes the pin an output with `pad_oe` high, and `pad_out` then carries the latch bit. A write takes effect on the clock after it.
- R2: A read at address 1 returns the pad levels through a two-flop synchroniser. A level applied before clock edge k is returned after edge k+1.
- R3: A write at address 1 updates the output latch, and the new value is seen on `pad_out` after the write clock. The write does not change what address 1 reads back.
- R4: A write at address 2 has exactly the same effect on the latch and on `pad_out` as a write at address 1.
- R5: A read at address 2 returns the latch contents and not the pin levels.
- R6: Reset sets the direction register to the parameter `DIR_RST`. The default is 0x50, which makes bits 4 and 6 inputs and all other bits outputs. Reset also clears the latch to 0 and leaves all pull-ups off.
- R7: Address 3 bit 0 is an active-low global pull-up control, reset to 1. Address 4 is a per-pin pull-up mask, reset to all ones. `pad_pu[i]` is high only when the control bit is 0, mask bit i is 1, and pin i is an input.
- R8: A pin whose resolved direction is output never has its pull-up enabled. This also holds when an override forces the pin to output.
- R9: When `ovr_en[i]` is 1, pin i takes its direction from `ovr_dir[i]` (1 means input, 0 means output) regardless of the direction register. When `ovr_en[i]` is 0, the register bit applies.
- R10: Read-data bits at and above `WIDTH` read as 0, and write-data bits at and above `WIDTH` are ignored. Addresses 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for `addr`, combinational |
| pad_in | input | WIDTH | Raw pad levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables, 1 means driving |
| pad_pu | output | WIDTH | Weak pull-up enables |
| ovr_en | input | WIDTH | Per-pin peripheral direction override enable |
| ovr_dir | input | WIDTH | Override direction, 1 means input |

## Verification
The hardest case to reach is a pin whose pull-up depends on three things at the same moment: the global control, the mask, and a resolved direction that an override can flip on any cycle. The bench first enables the pull-ups with every pin set as input. It then narrows the mask and clears single direction bits. After that it applies overrides that force an output onto a register input, and the reverse. A long phase follows with random writes, pad levels and overrides, and a behavioural model checks every output on every clock.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH  = 8,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3,
  parameter logic [WIDTH-1:0] DIR_RST = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu,
  input  logic [WIDTH-1:0]  ovr_en,
  input  logic [WIDTH-1:0]  ovr_dir
);
  localparam logic [ADDR_W-1:0] A_DIR  = 0;
  localparam logic [ADDR_W-1:0] A_PIN  = 1;
  localparam logic [ADDR_W-1:0] A_LAT  = 2;
  localparam logic [ADDR_W-1:0] A_PCTL = 3;
  localparam logic [ADDR_W-1:0] A_PMSK = 4;

  logic [WIDTH-1:0] dir_q, lat_q, msk_q, sync1_q, sync2_q, in_dir;
  logic             pu_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= DIR_RST;
      lat_q    <= '0;
      msk_q    <= '1;
      pu_off_q <= 1'b1;
      sync1_q  <= '0;
      sync2_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (wr_en) begin
        case (addr)
          A_DIR:        dir_q    <= wdata[WIDTH-1:0];
          A_PIN, A_LAT: lat_q    <= wdata[WIDTH-1:0];
          A_PCTL:       pu_off_q <= wdata[0];
          A_PMSK:       msk_q    <= wdata[WIDTH-1:0];
          default: ;
        endcase
      end
    end
  end

  assign in_dir  = (ovr_en & ovr_dir) | (~ovr_en & dir_q);
  assign pad_oe  = ~in_dir;
  assign pad_out = lat_q;
  assign pad_pu  = pu_off_q ? '0 : (msk_q & in_dir);

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIR:  rdata[WIDTH-1:0] = dir_q;
      A_PIN:  rdata[WIDTH-1:0] = sync2_q;
      A_LAT:  rdata[WIDTH-1:0] = lat_q;
      A_PCTL: rdata[0]         = pu_off_q;
      A_PMSK: rdata[WIDTH-1:0] = msk_q;
      default: ;
    endcase
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (((pad_oe ^ ~$past(wdata[WIDTH-1:0])) & ~ovr_en) == '0));

  assert_pin_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && addr == A_PIN) |-> (rdata[WIDTH-1:0] == $past(pad_in, 2)));

  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_PIN || addr == A_LAT)) |=> (pad_out == $past(wdata[WIDTH-1:0])));

  assert_latch_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_LAT) |-> (rdata == BUS_W'(pad_out)));

  assert_pull_global_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PCTL && wdata[0]) |=> (pad_pu == '0));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int W = 8;
  localparam int B = 16;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [2:0]   addr = 0;
  logic         wr_en = 0;
  logic [B-1:0] wdata = 0;
  logic [B-1:0] rdata;
  logic [W-1:0] pad_in = 0, pad_out, pad_oe, pad_pu, ovr_en = 0, ovr_dir = 0;

  int checks = 0, fails = 0, cycles = 0;
  bit started = 0;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .ovr_en(ovr_en), .ovr_dir(ovr_dir));

  always #5 clk = ~clk;

  // behavioural reference
  logic [W-1:0] m_dir, m_lat, m_msk;
  logic         m_off;
  logic [W-1:0] pin_hist[$];

  always @(posedge clk) begin
    started <= 1;
    cycles  <= cycles + 1;
    if (!rst_n) begin
      m_dir = 8'h50; m_lat = 0; m_msk = 8'hFF; m_off = 1;
      pin_hist = {8'h00, 8'h00};
    end else begin
      pin_hist.push_back(pad_in);
      void'(pin_hist.pop_front());
      if (wr_en) begin
        if (addr == 0) m_dir = wdata[W-1:0];
        if (addr == 1 || addr == 2) m_lat = wdata[W-1:0];
        if (addr == 3) m_off = wdata[0];
        if (addr == 4) m_msk = wdata[W-1:0];
      end
    end
  end

  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = ovr_en[i] ? !ovr_dir[i] : !m_dir[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_pu();
    return m_off ? '0 : (m_msk & ~exp_oe());
  endfunction

  function automatic logic [B-1:0] exp_rd();
    case (addr)
      3'd0: return B'(m_dir);
      3'd1: return B'(pin_hist[0]);
      3'd2: return B'(m_lat);
      3'd3: return B'(m_off);
      3'd4: return B'(m_msk);
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [B-1:0] act, logic [B-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R1/R9 pad_oe", B'(pad_oe), B'(exp_oe()));
    chk("R3/R4 pad_out", B'(pad_out), B'(m_lat));
    chk("R7/R8 pad_pu", B'(pad_pu), B'(exp_pu()));
    chk(addr == 1 ? "R2 pin read" : addr == 2 ? "R5 latch read" :
        addr > 4 ? "R10 unmapped read" : "R6/R10 register read", rdata, exp_rd());
  end

  task automatic step();
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [B-1:0] d);
    addr = a; wdata = d; wr_en = 1;
    step();
  endtask

  task automatic rd_at_neg(logic [2:0] a, string tag, logic [B-1:0] exp);
    addr = a;
    @(negedge clk); #1;
    chk(tag, rdata, exp);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R6 reset state
    rd_at_neg(0, "R6 reset direction", 16'h0050);
    chk("R6 reset pull-ups off", B'(pad_pu), 0);
    chk("R6 reset latch", B'(pad_out), 0);
    rd_at_neg(3, "R7 reset control bit", 16'h0001);
    // R3, R5, R2
    wr(0, 16'h0000);
    wr(1, 16'h00A5);
    pad_in = 8'h3C;
    step(); step();
    rd_at_neg(1, "R2 pins read back", 16'h003C);
    rd_at_neg(2, "R5 latch read back", 16'h00A5);
    chk("R3 pad_out after pin write", B'(pad_out), 16'h00A5);
    // R4
    wr(2, 16'h005A);
    chk("R4 latch write drives pad_out", B'(pad_out), 16'h005A);
    // R7 / R8 / R9
    wr(0, 16'h00FF);
    wr(3, 16'h0000);
    chk("R7 pulls on all inputs", B'(pad_pu), 16'h00FF);
    wr(4, 16'h000F);
    chk("R7 mask limits pulls", B'(pad_pu), 16'h000F);
    wr(0, 16'h00FE);
    chk("R8 output pin loses pull", B'(pad_pu), 16'h000E);
    ovr_en = 8'h02; ovr_dir = 8'h00;
    #1 chk("R9 override forces output", B'(pad_oe), 16'h0003);
    chk("R8 override output loses pull", B'(pad_pu), 16'h000C);
    wr(0, 16'h007F);
    ovr_en = 8'h80; ovr_dir = 8'h80;
    #1 chk("R9 override forces input", B'(pad_oe), 16'h0000);
    ovr_en = 0; ovr_dir = 0;
    // R10
    wr(0, 16'hFF00);
    rd_at_neg(0, "R10 upper write bits ignored", 16'h0000);
    wr(0, 16'hFFFF);
    rd_at_neg(0, "R10 upper read bits zero", 16'h00FF);
    wr(5, 16'h1234);
    rd_at_neg(5, "R10 unmapped reads zero", 16'h0000);
    rd_at_neg(2, "R10 unmapped write left latch", 16'h005A);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      addr    = 3'($urandom_range(0, 7));
      wdata   = 16'($urandom);
      wr_en   = ($urandom_range(0, 3) == 0);
      pad_in  = 8'($urandom);
      ovr_en  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      ovr_dir = 8'($urandom);
      @(posedge clk); #2;
    end
    wr_en = 0;
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule